// File: doc/BRIEF.md
# Floating-Point Exception Trap Decision Unit

This block sits behind a floating-point datapath. It turns the raw exception signals of one operation into a trap decision and updated status fields. Each operation is presented for one cycle with a `valid` strobe. The strobe carries five inputs: an invalid-operation flag, an overflow flag (already judged after rounding by the datapath), a divide-by-zero flag, a tininess flag and an inexact flag. Tininess means the exact unrounded result is nonzero and below the smallest normal magnitude. The inexact flag means the rounded result differs from the exact one. A five-bit trap-enable mask comes from the status register.

The unit applies the underflow rule first, and that rule depends on whether the underflow trap is enabled. It then decides whether any enabled exception is present. A trapping operation blocks the write of the destination register and condition codes, which is signalled by a low `write_enable`. It leaves the accrued field alone and loads a one-hot current field that names the single cause. A non-trapping operation replaces the current field and merges into the accrued field. All outputs are registered and appear one clock after the strobe.

Top module: `fpx_trap_unit`

## Requirements
- R1: After reset `trap`, `write_enable`, `cur_exc` and `acc_exc` are all zero.
- R2: The bit positions in `cur_exc`, `acc_exc` and `trap_mask` are: bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact. An operation with no enabled exception gives `write_enable`=1 and `trap`=0 one cycle after `valid`. It also sets `cur_exc` to this operation's exception bits and ORs them into `acc_exc`. The overflow input is taken as reported and is not re-derived.
- R3: An operation with at least one enabled exception gives `trap`=1 and `write_enable`=0 one cycle after `valid`, and leaves `acc_exc` unchanged.
- R4: On a trap, `cur_exc` holds exactly one set bit, the bit of the exception that caused the trap.
- R5: When several enabled exceptions coincide, the cause is the one at the highest bit position: invalid, overflow, underflow, divide-by-zero, then inexact. Exceptions whose enable is clear never cause a trap.
- R6: With mask bit 2 set, a tiny result flags underflow even when it is exact, so an exact tiny result traps as underflow.
- R7: With mask bit 2 clear, underflow is flagged only if the result is both tiny and inexact. An exact tiny result then raises no exception at all.
- R8: With mask bit 2 clear, a tiny inexact result traps as inexact if mask bit 0 is set. If neither bit is set, it sets both bit 2 and bit 0 in `cur_exc` and `acc_exc`.
- R9: `trap` and `write_enable` are single-cycle pulses. While `valid` is low the exception inputs are ignored: both pulses stay low and `cur_exc`/`acc_exc` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | One-cycle strobe qualifying the exception inputs |
| exc_invalid | input | 1 | Invalid-operation indication |
| exc_overflow | input | 1 | Overflow indication, judged after rounding |
| exc_divzero | input | 1 | Divide-by-zero indication |
| res_tiny | input | 1 | Exact result nonzero and below minimum normal magnitude |
| res_inexact | input | 1 | Rounded result differs from the exact result |
| trap_mask | input | 5 | Trap enables, same bit order as the exception fields |
| trap | output | 1 | One-cycle trap pulse |
| write_enable | output | 1 | One-cycle permission to write destination and condition codes |
| cur_exc | output | 5 | Current-exception field |
| acc_exc | output | 5 | Accrued-exception field |

## Verification
The bench aims at the underflow split. It checks an exact tiny result with and without the underflow enable: a design that always requires inexactness never traps in the first case, and one that never requires it raises underflow in the second. Tiny inexact results are run under each mask combination, so a swapped fallback order or a missing paired inexact bit shows up. Coincident enabled exceptions expose a wrong priority or a multi-hot current field. Trapping operations that follow accrued ones catch a design that merges trapped exceptions into the accrued field.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned NEXC   = 5;
  localparam int unsigned IDX_NX = 0;
  localparam int unsigned IDX_DZ = 1;
  localparam int unsigned IDX_UF = 2;
  localparam int unsigned IDX_OF = 3;
  localparam int unsigned IDX_NV = 4;

  typedef logic [NEXC-1:0] exc_vec_t;

  // Underflow flag: trap enabled -> tininess alone; disabled -> tiny and inexact.
  function automatic logic uf_flag(input logic uf_trap_on, input logic tiny,
                                   input logic inexact);
    return tiny & (uf_trap_on | inexact);
  endfunction

  function automatic exc_vec_t pack_exc(input logic nv, input logic of_,
                                        input logic uf, input logic dz,
                                        input logic nx);
    exc_vec_t v;
    v         = '0;
    v[IDX_NV] = nv;
    v[IDX_OF] = of_;
    v[IDX_UF] = uf;
    v[IDX_DZ] = dz;
    v[IDX_NX] = nx;
    return v;
  endfunction
endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
  import fpx_pkg::*;
(
  input  logic     exc_invalid,
  input  logic     exc_overflow,
  input  logic     exc_divzero,
  input  logic     res_tiny,
  input  logic     res_inexact,
  input  logic     uf_trap_on,
  output exc_vec_t raw_exc
);
  logic uf_raised;

  assign uf_raised = uf_flag(uf_trap_on, res_tiny, res_inexact);
  assign raw_exc   = pack_exc(exc_invalid, exc_overflow, uf_raised,
                              exc_divzero, res_inexact);
endmodule

// File: rtl/fpx_priority.sv
module fpx_priority #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  // Highest index wins; each bit is blocked by any request above it.
  logic [N:0] above;

  assign above[N] = 1'b0;

  for (genvar i = N - 1; i >= 0; i--) begin : g_pick
    assign grant[i] = req[i] & ~above[i+1];
    assign above[i] = above[i+1] | req[i];
  end

  assign any = above[0];
endmodule

// File: rtl/fpx_status_regs.sv
module fpx_status_regs
  import fpx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     valid,
  input  exc_vec_t raw_exc,
  input  exc_vec_t cause,
  input  logic     take_trap,
  output logic     trap,
  output logic     write_enable,
  output exc_vec_t cur_exc,
  output exc_vec_t acc_exc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap         <= 1'b0;
      write_enable <= 1'b0;
      cur_exc      <= '0;
      acc_exc      <= '0;
    end else begin
      trap         <= valid & take_trap;
      write_enable <= valid & ~take_trap;
      if (valid) begin
        if (take_trap) begin
          cur_exc <= cause;
        end else begin
          cur_exc <= raw_exc;
          acc_exc <= acc_exc | raw_exc;
        end
      end
    end
  end

  p_trap_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !write_enable);

  p_trap_acc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (acc_exc == $past(acc_exc)));

  p_trap_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> ($countones(cur_exc) == 1));

  p_acc_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_exc & $past(acc_exc)) == $past(acc_exc));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> (!trap && !write_enable && $stable(cur_exc) && $stable(acc_exc)));
endmodule

// File: rtl/fpx_trap_unit.sv
module fpx_trap_unit
  import fpx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic            exc_invalid,
  input  logic            exc_overflow,
  input  logic            exc_divzero,
  input  logic            res_tiny,
  input  logic            res_inexact,
  input  logic [NEXC-1:0] trap_mask,
  output logic            trap,
  output logic            write_enable,
  output logic [NEXC-1:0] cur_exc,
  output logic [NEXC-1:0] acc_exc
);
  exc_vec_t raw_exc;
  exc_vec_t enabled_exc;
  exc_vec_t cause;
  logic     take_trap;

  fpx_classify u_classify (
    .exc_invalid (exc_invalid),
    .exc_overflow(exc_overflow),
    .exc_divzero (exc_divzero),
    .res_tiny    (res_tiny),
    .res_inexact (res_inexact),
    .uf_trap_on  (trap_mask[IDX_UF]),
    .raw_exc     (raw_exc)
  );

  assign enabled_exc = raw_exc & trap_mask;

  fpx_priority #(.N(NEXC)) u_priority (
    .req  (enabled_exc),
    .grant(cause),
    .any  (take_trap)
  );

  fpx_status_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (valid),
    .raw_exc     (raw_exc),
    .cause       (cause),
    .take_trap   (take_trap),
    .trap        (trap),
    .write_enable(write_enable),
    .cur_exc     (cur_exc),
    .acc_exc     (acc_exc)
  );

  p_exact_tiny_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && res_tiny && trap_mask[IDX_UF] && !exc_invalid && !exc_overflow)
    |=> (trap && cur_exc[IDX_UF]));

  p_exact_tiny_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && res_tiny && !res_inexact && !trap_mask[IDX_UF])
    |=> !cur_exc[IDX_UF]);

  p_masked_never_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (trap_mask == '0)) |=> (!trap && write_enable));
endmodule

// File: tb/fpx_trap_unit_tb.sv
`timescale 1ns/1ps
module fpx_trap_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic       exc_invalid = 1'b0, exc_overflow = 1'b0, exc_divzero = 1'b0;
  logic       res_tiny = 1'b0, res_inexact = 1'b0;
  logic [4:0] trap_mask = '0;
  logic       trap, write_enable;
  logic [4:0] cur_exc, acc_exc;

  int errors = 0;
  int checks = 0;
  logic [4:0] acc_model = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fpx_trap_unit u_dut (
    .clk(clk), .rst_n(rst_n), .valid(valid),
    .exc_invalid(exc_invalid), .exc_overflow(exc_overflow),
    .exc_divzero(exc_divzero), .res_tiny(res_tiny), .res_inexact(res_inexact),
    .trap_mask(trap_mask), .trap(trap), .write_enable(write_enable),
    .cur_exc(cur_exc), .acc_exc(acc_exc)
  );

  // [15:11] {invalid, overflow, divzero, tiny, inexact}, [10:6] mask,
  // [5] expected trap, [4:0] expected current field (bit4 nv .. bit0 nx).
  localparam int NV = 16;
  localparam logic [15:0] VEC [NV] = '{
    {5'b00000, 5'b00000, 1'b0, 5'b00000}, // R2 nothing
    {5'b00001, 5'b00000, 1'b0, 5'b00001}, // R2 inexact only
    {5'b01001, 5'b00000, 1'b0, 5'b01001}, // R2 overflow+inexact
    {5'b00100, 5'b00000, 1'b0, 5'b00010}, // R2 divzero
    {5'b10000, 5'b11111, 1'b1, 5'b10000}, // R3 R4 invalid trap
    {5'b01001, 5'b11111, 1'b1, 5'b01000}, // R5 overflow over inexact
    {5'b00010, 5'b00100, 1'b1, 5'b00100}, // R6 exact tiny traps
    {5'b00010, 5'b00000, 1'b0, 5'b00000}, // R7 exact tiny quiet
    {5'b00011, 5'b00100, 1'b1, 5'b00100}, // R8 tiny inexact, uf trap
    {5'b00011, 5'b00001, 1'b1, 5'b00001}, // R8 fallback to inexact trap
    {5'b00011, 5'b00000, 1'b0, 5'b00101}, // R8 both bits untrapped
    {5'b00101, 5'b00011, 1'b1, 5'b00010}, // R5 divzero over inexact
    {5'b10100, 5'b00010, 1'b1, 5'b00010}, // R5 disabled invalid ignored
    {5'b00010, 5'b11011, 1'b0, 5'b00000}, // R7 exact tiny, others enabled
    {5'b11011, 5'b01111, 1'b1, 5'b01000}, // R5 overflow over uf/nx
    {5'b00010, 5'b00001, 1'b0, 5'b00000}  // R7 exact tiny, nx enabled
  };

  task automatic check(input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] ins, input logic [4:0] m,
                       input logic v);
    @(negedge clk);
    {exc_invalid, exc_overflow, exc_divzero, res_tiny, res_inexact} = ins;
    trap_mask = m;
    valid = v;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {1'b0, trap, write_enable, cur_exc}, 8'h00);
    check("R1 reset accrued", {3'b0, acc_exc}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      apply(v[15:11], v[10:6], 1'b1);
      if (!v[5]) acc_model = acc_model | v[4:0];
      check($sformatf("R2 R3 R4 R5 R6 R7 R8 vec %0d trap/we", i),
            {6'b0, trap, write_enable}, {6'b0, v[5], ~v[5]});
      check($sformatf("R2 R4 vec %0d cur", i), {3'b0, cur_exc}, {3'b0, v[4:0]});
      check($sformatf("R2 R3 vec %0d acc", i), {3'b0, acc_exc}, {3'b0, acc_model});
    end

    // R9: pulses drop the cycle after; inputs ignored while valid is low
    apply(5'b10000, 5'b11111, 1'b1);
    check("R3 directed trap", {7'b0, trap}, 8'h01);
    @(negedge clk);
    check("R9 trap pulse ends", {6'b0, trap, write_enable}, 8'h00);
    apply(5'b11111, 5'b11111, 1'b0);
    check("R9 ignored trap/we", {6'b0, trap, write_enable}, 8'h00);
    check("R9 ignored cur", {3'b0, cur_exc}, 8'h10);
    check("R9 ignored acc", {3'b0, acc_exc}, {3'b0, acc_model});
    apply(5'b00100, 5'b00000, 1'b1);
    acc_model = acc_model | 5'b00010;
    check("R2 write pulse", {6'b0, trap, write_enable}, 8'h01);
    @(negedge clk);
    check("R9 write pulse ends", {6'b0, trap, write_enable}, 8'h00);

    // R1: reset again clears accrued state
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset", {3'b0, acc_exc}, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule